// File: doc/BRIEF.md
# Branch History Recorder

This block keeps a circular history of the most recent taken control-flow transfers seen at branch retirement. Each retired branch arrives already classified: a 63-bit source address, a 64-bit target address, a class code, a flag saying whether the target runs at the most privileged level, and a mispredict flag. A 9-bit suppress mask drops branches by class and by target privilege. Every branch that passes the mask is written into the slot after the current top-of-stack, and the top-of-stack then moves to that slot.

A control register enables recording. It also arms a freeze that a performance-monitor interrupt triggers. Once the freeze is set, the history stays untouched until software releases it, so a sampling handler can read a stable picture. The read port is indexed from newest to oldest. Index 0 returns the entry written last. The stored source word carries the mispredict flag in its top bit, and a reader recovers the full address by copying bit 62 into bit 63.

Top module: `branch_hist`

## Requirements
- R1: After reset, `tos` is 0 and every slot reads as zero. Each recorded branch moves `tos` up by one, wrapping modulo DEPTH (a power of two, 4 to 16).
- R2: Read index i returns the slot at (tos - i) mod DEPTH, so i = 0 is the newest entry and i = DEPTH-1 is the oldest.
- R3: Class codes are 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far transfer. A set bit 2+code in the suppress mask drops that class. Code 7 is never recorded.
- R4: Suppress bit 0 drops branches whose target is privileged (`br_to_kernel`=1). Bit 1 drops branches whose target is unprivileged. The test uses the target privilege and ignores the source.
- R5: A mask write keeps only `sel_wdata[8:0]`. `sel_rd[15:9]` always reads zero.
- R6: Bit 63 of a stored source word is the mispredict flag. Bits 62:0 are the source address. The target word is stored as all 64 bits.
- R7: With control bit 0 (enable) clear, no branch is recorded and the stored contents stay as they were.
- R8: With control bits 0 and 1 both set, `pmi` sets `frozen` on the next cycle. A branch in the same cycle as `pmi` is still recorded. While `frozen` is set, no branch is recorded.
- R9: `frozen` stays set until a `frz_clr` pulse. If `pmi` re-arms the freeze in the same cycle as `frz_clr`, `frozen` stays set.
- R10: `stk_clr` zeroes every slot on the next cycle and leaves `tos` unchanged. A branch offered in the same cycle is dropped.
- R11: A mask or control write in the same cycle as a branch takes effect from the next cycle. The branch is judged against the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A taken branch retires this cycle |
| br_from | input | 63 | Source address, bits 62:0 |
| br_to | input | 64 | Target address |
| br_class | input | 3 | Resolved branch class code |
| br_to_kernel | input | 1 | Target runs at the most privileged level |
| br_mispred | input | 1 | Branch was mispredicted |
| sel_we | input | 1 | Write the suppress mask |
| sel_wdata | input | 16 | Suppress mask write data |
| ctl_we | input | 1 | Write the control register |
| ctl_wdata | input | 2 | Bit 0 enable, bit 1 freeze on interrupt |
| pmi | input | 1 | Performance-monitor interrupt |
| frz_clr | input | 1 | Release the freeze |
| stk_clr | input | 1 | Zero all slots |
| rd_idx | input | IW | Newest-first read index |
| rd_from | output | 64 | Stored source word at the read index |
| rd_to | output | 64 | Stored target word at the read index |
| tos | output | IW | Slot of the most recent entry |
| sel_rd | output | 16 | Suppress mask readback |
| ctl_rd | output | 2 | Control register readback |
| frozen | output | 1 | Recording is frozen |

## Verification
The assertions watch several rules on every cycle. The top-of-stack steps by one on each accepted branch and holds otherwise, including across a clear. A clear zeroes every slot. Nothing is captured while frozen, while disabled, for class code 7, or against a set privilege bit. The freeze flag sets, holds and releases as R8 and R9 say.

Other behaviour needs a sequence of stimuli and is shown by the bench scenarios. This covers the newest-first order after the pointer wraps, the class-by-class mask table, and the mispredict packing with address recovery. It also covers a register write landing in the same cycle as a branch, and the stored contents surviving a disabled period.

// File: rtl/branch_hist_pkg.sv
package branch_hist_pkg;

  localparam int ADDR_W   = 64;
  localparam int SEL_W    = 9;
  localparam int CFG_W    = 16;
  localparam int SUP_PRIV = 0;
  localparam int SUP_USER = 1;
  localparam int SUP_CLS0 = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [ADDR_W-2:0] src_t;

  typedef enum logic [2:0] {
    BC_COND  = 3'd0,
    BC_RCALL = 3'd1,
    BC_ICALL = 3'd2,
    BC_RET   = 3'd3,
    BC_IJMP  = 3'd4,
    BC_RJMP  = 3'd5,
    BC_FAR   = 3'd6,
    BC_RSVD  = 3'd7
  } br_class_e;

  typedef struct packed {
    logic frz_on_int;
    logic en;
  } ctl_t;

  // Source word as stored: flag on top, address below.
  function automatic addr_t pack_from(src_t src, logic mis);
    return {mis, src};
  endfunction

  // Keep only the implemented mask bits of a write.
  function automatic logic [CFG_W-1:0] mask_sel(logic [CFG_W-1:0] w);
    return w & CFG_W'((1 << SEL_W) - 1);
  endfunction

  // One-hot mask position of a class.
  function automatic logic [SEL_W-1:0] class_bit(br_class_e c);
    return SEL_W'(1) << (SUP_CLS0 + int'(c));
  endfunction

  // High when the mask drops this branch.
  function automatic logic is_suppressed(logic [SEL_W-1:0] sel, br_class_e c,
                                         logic to_kern);
    logic priv_hit;
    priv_hit = to_kern ? sel[SUP_PRIV] : sel[SUP_USER];
    if (c == BC_RSVD) return 1'b1;
    return priv_hit | (|(sel & class_bit(c)));
  endfunction

  // Slot of the i-th newest entry.
  function automatic int newest_slot(int top, int i, int depth);
    return (top - i) & (depth - 1);
  endfunction

endpackage

// File: rtl/branch_hist_ctrl.sv
module branch_hist_ctrl
  import branch_hist_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [CFG_W-1:0] sel_wdata,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_wdata,
  input  logic             pmi,
  input  logic             frz_clr,
  output logic [CFG_W-1:0] sel_q,
  output ctl_t             ctl_q,
  output logic             frozen,
  output logic             freeze_evt
);

  assign freeze_evt = pmi & ctl_q.en & ctl_q.frz_on_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_we) begin
      sel_q <= mask_sel(sel_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_t'(ctl_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen <= 1'b0;
    end else if (freeze_evt) begin
      frozen <= 1'b1;
    end else if (frz_clr) begin
      frozen <= 1'b0;
    end
  end

  assert_freeze_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_evt |=> frozen);
  assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !frz_clr |=> frozen);
  assert_freeze_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && frz_clr && !freeze_evt |=> !frozen);
  assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(sel_q));
  assert_sel_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[CFG_W-1:SEL_W] == '0);

endmodule

// File: rtl/branch_hist_filter.sv
module branch_hist_filter
  import branch_hist_pkg::*;
(
  input  logic             br_valid,
  input  br_class_e        br_class,
  input  logic             to_kern,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  input  logic             frozen,
  output logic             sup_hit,
  output logic             cap_fire
);

  always_comb begin
    sup_hit  = is_suppressed(sel, br_class, to_kern);
    cap_fire = br_valid & en & ~frozen & ~sup_hit;
  end

endmodule

// File: rtl/branch_hist_store.sv
module branch_hist_store
  import branch_hist_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_fire,
  input  logic          clr,
  input  addr_t         wr_from,
  input  addr_t         wr_to,
  input  logic [IW-1:0] rd_idx,
  output addr_t         rd_from,
  output addr_t         rd_to,
  output logic [IW-1:0] tos
);

  addr_t         from_q [DEPTH];
  addr_t         to_q   [DEPTH];
  logic [IW-1:0] tos_q;
  logic [IW-1:0] wr_slot;
  logic [IW-1:0] rd_slot;
  logic          wr_ok;

  assign wr_ok   = cap_fire & ~clr;
  assign wr_slot = tos_q + IW'(1);
  assign rd_slot = IW'(newest_slot(int'(tos_q), int'(rd_idx), DEPTH));
  assign rd_from = from_q[rd_slot];
  assign rd_to   = to_q[rd_slot];
  assign tos     = tos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos_q <= '0;
    end else if (wr_ok) begin
      tos_q <= wr_slot;
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        from_q[k] <= '0;
        to_q[k]   <= '0;
      end else if (clr) begin
        from_q[k] <= '0;
        to_q[k]   <= '0;
      end else if (wr_ok && wr_slot == IW'(k)) begin
        from_q[k] <= wr_from;
        to_q[k]   <= wr_to;
      end
    end

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> from_q[k] == '0 && to_q[k] == '0);
  end

  assert_tos_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> tos_q == IW'($past(tos_q) + IW'(1)));
  assert_tos_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(tos_q));
  assert_write_land_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> from_q[tos_q] == $past(wr_from) && to_q[tos_q] == $past(wr_to));

endmodule

// File: rtl/branch_hist.sv
module branch_hist
  import branch_hist_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [ADDR_W-2:0] br_from,
  input  logic [ADDR_W-1:0] br_to,
  input  logic [2:0]        br_class,
  input  logic              br_to_kernel,
  input  logic              br_mispred,
  input  logic              sel_we,
  input  logic [CFG_W-1:0]  sel_wdata,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_wdata,
  input  logic              pmi,
  input  logic              frz_clr,
  input  logic              stk_clr,
  input  logic [IW-1:0]     rd_idx,
  output logic [ADDR_W-1:0] rd_from,
  output logic [ADDR_W-1:0] rd_to,
  output logic [IW-1:0]     tos,
  output logic [CFG_W-1:0]  sel_rd,
  output logic [1:0]        ctl_rd,
  output logic              frozen
);

  logic [CFG_W-1:0] sel_q;
  ctl_t             ctl_q;
  logic             freeze_evt;
  logic             sup_hit;
  logic             cap_fire;
  addr_t            wr_from;

  assign wr_from = pack_from(br_from, br_mispred);
  assign sel_rd  = sel_q;
  assign ctl_rd  = ctl_q;

  branch_hist_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_we     (sel_we),
    .sel_wdata  (sel_wdata),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .pmi        (pmi),
    .frz_clr    (frz_clr),
    .sel_q      (sel_q),
    .ctl_q      (ctl_q),
    .frozen     (frozen),
    .freeze_evt (freeze_evt)
  );

  branch_hist_filter i_filter (
    .br_valid (br_valid),
    .br_class (br_class_e'(br_class)),
    .to_kern  (br_to_kernel),
    .sel      (sel_q[SEL_W-1:0]),
    .en       (ctl_q.en),
    .frozen   (frozen),
    .sup_hit  (sup_hit),
    .cap_fire (cap_fire)
  );

  branch_hist_store #(.DEPTH(DEPTH)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_fire (cap_fire),
    .clr      (stk_clr),
    .wr_from  (wr_from),
    .wr_to    (br_to),
    .rd_idx   (rd_idx),
    .rd_from  (rd_from),
    .rd_to    (rd_to),
    .tos      (tos)
  );

  assert_frozen_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !cap_fire);
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rd[0] |-> !cap_fire);
  assert_reserved_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    br_class == 3'd7 |-> !cap_fire);
  assert_priv_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_to_kernel ? sel_rd[0] : sel_rd[1]) |-> !cap_fire);

endmodule

// File: tb/test_branch_hist.sv
module test_branch_hist;

  localparam int  DEPTH   = 16;
  localparam int  IW      = $clog2(DEPTH);
  localparam time CLK_PER = 10ns;

  typedef struct packed {
    logic [8:0] sel;
    logic [2:0] cls;
    logic       kern;
    logic       exp;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{9'h000, 3'd0, 1'b0, 1'b1},
    '{9'h004, 3'd0, 1'b0, 1'b0},
    '{9'h004, 3'd1, 1'b0, 1'b1},
    '{9'h008, 3'd1, 1'b1, 1'b0},
    '{9'h010, 3'd2, 1'b1, 1'b0},
    '{9'h020, 3'd3, 1'b0, 1'b0},
    '{9'h040, 3'd4, 1'b0, 1'b0},
    '{9'h080, 3'd5, 1'b1, 1'b0},
    '{9'h100, 3'd6, 1'b0, 1'b0},
    '{9'h001, 3'd6, 1'b1, 1'b0},
    '{9'h001, 3'd6, 1'b0, 1'b1},
    '{9'h002, 3'd3, 1'b0, 1'b0},
    '{9'h002, 3'd3, 1'b1, 1'b1},
    '{9'h000, 3'd7, 1'b0, 1'b0},
    '{9'h1fc, 3'd5, 1'b1, 1'b0},
    '{9'h003, 3'd0, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          br_valid, br_to_kernel, br_mispred;
  logic [62:0]   br_from;
  logic [63:0]   br_to;
  logic [2:0]    br_class;
  logic          sel_we, ctl_we, pmi, frz_clr, stk_clr;
  logic [15:0]   sel_wdata;
  logic [1:0]    ctl_wdata;
  logic [IW-1:0] rd_idx;
  logic [63:0]   rd_from, rd_to;
  logic [IW-1:0] tos;
  logic [15:0]   sel_rd;
  logic [1:0]    ctl_rd;
  logic          frozen;

  int checks = 0;
  int errors = 0;
  int ntot   = 0;
  int nvalid = 0;
  logic [63:0] hist_f [256];
  logic [63:0] hist_t [256];

  always #(CLK_PER/2) clk = ~clk;

  branch_hist #(.DEPTH(DEPTH)) i_branch_hist (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_from(br_from),
    .br_to(br_to), .br_class(br_class), .br_to_kernel(br_to_kernel),
    .br_mispred(br_mispred), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .pmi(pmi), .frz_clr(frz_clr),
    .stk_clr(stk_clr), .rd_idx(rd_idx), .rd_from(rd_from), .rd_to(rd_to),
    .tos(tos), .sel_rd(sel_rd), .ctl_rd(ctl_rd), .frozen(frozen)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_br(input logic [62:0] f, input logic [63:0] t, input logic [2:0] c,
                        input logic k, input logic m, input logic exp);
    br_from = f; br_to = t; br_class = c; br_to_kernel = k; br_mispred = m;
    br_valid = 1'b1;
    @(negedge clk);
    br_valid = 1'b0;
    if (exp) begin
      hist_f[ntot] = {m, f};
      hist_t[ntot] = t;
      ntot++;
      nvalid++;
    end
  endtask

  task automatic wr_sel(input logic [15:0] v);
    sel_wdata = v; sel_we = 1'b1;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [1:0] v);
    ctl_wdata = v; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // Full newest-first dump against the model.
  task automatic check_all(input string req);
    logic [63:0] ef, et;
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = IW'(i);
      #1;
      ef = (i < nvalid) ? hist_f[ntot-1-i] : 64'd0;
      et = (i < nvalid) ? hist_t[ntot-1-i] : 64'd0;
      chk(req, rd_from, ef);
      chk(req, rd_to, et);
    end
    rd_idx = '0;
    chk(req, 64'(tos), 64'(ntot % DEPTH));
  endtask

  initial begin
    rst_n = 1'b0;
    br_valid = 0; br_from = '0; br_to = '0; br_class = '0; br_to_kernel = 0;
    br_mispred = 0; sel_we = 0; sel_wdata = '0; ctl_we = 0; ctl_wdata = '0;
    pmi = 0; frz_clr = 0; stk_clr = 0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1 reset contents");
    chk("R1 reset sel", 64'(sel_rd), 64'd0);
    chk("R1 reset ctl", 64'(ctl_rd), 64'd0);
    chk("R1 reset frozen", 64'(frozen), 64'd0);

    // R5 mask write keeps nine bits
    wr_sel(16'hffff);
    chk("R5 sel mask", 64'(sel_rd), 64'h1ff);
    wr_sel(16'h0000);

    // R7 disabled: nothing recorded
    put_br(63'h111, 64'h222, 3'd0, 1'b0, 1'b0, 1'b0);
    chk("R7 disabled tos", 64'(tos), 64'd0);

    // R3 R4 vector table
    wr_ctl(2'b01);
    for (int v = 0; v < NVEC; v++) begin
      wr_sel({7'd0, VECS[v].sel});
      put_br(63'h1000 + 63'(v * 16), 64'h8000 + 64'(v * 16), VECS[v].cls,
             VECS[v].kern, 1'b0, VECS[v].exp);
      chk($sformatf("R3 R4 vector %0d tos", v), 64'(tos), 64'(ntot % DEPTH));
      if (VECS[v].exp) chk($sformatf("R3 R4 vector %0d newest", v), rd_from, hist_f[ntot-1]);
    end
    wr_sel(16'h0000);

    // R6 mispredict packing and address recovery
    put_br(63'h0000_7000_0000_1234, 64'h1, 3'd1, 1'b0, 1'b1, 1'b1);
    chk("R6 raw flag set", rd_from, 64'h8000_7000_0000_1234);
    chk("R6 recovered", {rd_from[62], rd_from[62:0]}, 64'h0000_7000_0000_1234);
    put_br(63'h7fff_8000_0000_5678, 64'hffff_8000_0000_9abc, 3'd6, 1'b1, 1'b0, 1'b1);
    chk("R6 raw flag clear", rd_from, 64'h7fff_8000_0000_5678);
    chk("R6 recovered kernel", {rd_from[62], rd_from[62:0]}, 64'hffff_8000_0000_5678);
    chk("R6 to word", rd_to, 64'hffff_8000_0000_9abc);

    // R1 R2 wrap and newest-first order
    for (int n = 0; n < DEPTH + 3; n++)
      put_br(63'h4000 + 63'(n), 64'h5000 + 64'(n), 3'd5, 1'b0, 1'b0, 1'b1);
    check_all("R1 R2 wrap order");

    // R11 mask write in the same cycle as a branch
    sel_wdata = 16'h01ff; sel_we = 1'b1;
    put_br(63'h6000, 64'h6001, 3'd0, 1'b0, 1'b0, 1'b1);
    sel_we = 1'b0;
    chk("R11 same-cycle write uses old mask", rd_from, 64'h6000);
    put_br(63'h6010, 64'h6011, 3'd0, 1'b0, 1'b0, 1'b0);
    chk("R11 new mask active", 64'(tos), 64'(ntot % DEPTH));
    wr_sel(16'h0000);

    // R8 freeze on interrupt
    wr_ctl(2'b11);
    pmi = 1'b1;
    put_br(63'h7000, 64'h7001, 3'd2, 1'b1, 1'b0, 1'b1);
    pmi = 1'b0;
    chk("R8 frozen set", 64'(frozen), 64'd1);
    chk("R8 same-cycle branch kept", rd_from, 64'h7000);
    put_br(63'h7010, 64'h7011, 3'd2, 1'b1, 1'b0, 1'b0);
    chk("R8 frozen drops branch", 64'(tos), 64'(ntot % DEPTH));

    // R9 release rules
    pmi = 1'b1; frz_clr = 1'b1;
    @(negedge clk);
    pmi = 1'b0; frz_clr = 1'b0;
    chk("R9 interrupt beats release", 64'(frozen), 64'd1);
    repeat (3) @(negedge clk);
    chk("R9 stays frozen", 64'(frozen), 64'd1);
    frz_clr = 1'b1;
    @(negedge clk);
    frz_clr = 1'b0;
    chk("R9 released", 64'(frozen), 64'd0);
    put_br(63'h7020, 64'h7021, 3'd3, 1'b0, 1'b0, 1'b1);
    chk("R9 records after release", rd_from, 64'h7020);

    // R8 interrupt without the freeze bit
    wr_ctl(2'b01);
    pmi = 1'b1;
    @(negedge clk);
    pmi = 1'b0;
    chk("R8 no freeze when unarmed", 64'(frozen), 64'd0);

    // R7 disable keeps contents
    wr_ctl(2'b00);
    put_br(63'h7a00, 64'h7a01, 3'd0, 1'b0, 1'b0, 1'b0);
    check_all("R7 contents kept while disabled");
    wr_ctl(2'b01);

    // R10 clear, branch in same cycle dropped
    stk_clr = 1'b1;
    put_br(63'h7b00, 64'h7b01, 3'd0, 1'b0, 1'b0, 1'b0);
    stk_clr = 1'b0;
    nvalid = 0;
    check_all("R10 clear");
    put_br(63'h7c00, 64'h7c01, 3'd0, 1'b0, 1'b0, 1'b1);
    check_all("R10 record after clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule